// File: doc/BRIEF.md
# Dual-Resolution PWM Channel

This block produces one pulse-width-modulated waveform from an 8-bit duty value. A prescaler divides the system clock by 16, 32, 64 or 128 to make the PWM clock. A frame counter advances once per PWM clock and wraps after 32 counts in short (5-bit) mode or after 256 counts in long (8-bit) mode. The output is high while the frame counter is below the duty value, so a duty of M gives M high counts in each frame.

Software-side writes arrive on three separate strobes: one for the duty value, one for the control fields (resolution and prescaler select) and one for the pin routing bit. Duty and resolution are held in shadow registers and copied into the active copies only when a frame wraps, so a frame never mixes two settings. The prescaler select acts at once. The routing bit chooses whether the output pin carries the waveform or a general-purpose port value.

Top module: `pwm_dualres`

## Requirements
- R1: During and after reset the waveform output is low, the prescaler and frame counter start from zero, the active duty is zero and the routing bit is cleared, so the pin follows the port value.
- R2: With the resolution bit clear (long mode), a frame lasts 256 PWM clocks, and the waveform is high for the first M of them, where M is the full 8-bit duty value.
- R3: With the resolution bit set (short mode), a frame lasts 32 PWM clocks, and only duty bits [4:0] are used (for example, a duty of 0xE5 acts as 5).
- R4: The 2-bit prescaler select values 0, 1, 2 and 3 make one PWM clock last 16, 32, 64 and 128 system clocks.
- R5: A duty of 0 keeps the waveform low for the whole frame. The largest duty (31 in short mode, 255 in long mode) keeps it high for all counts of the frame except the last.
- R6: New duty and resolution values take effect only at the next frame wrap. The frame in progress completes with the old values.
- R7: When the routing bit is 1, the pin equals the waveform. When it is 0, the pin equals the port value one clock after that value is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_we | input | 1 | Write strobe for the duty shadow register |
| duty_wdata | input | 8 | Duty value to write |
| ctrl_we | input | 1 | Write strobe for the control fields |
| ctrl_short | input | 1 | Resolution bit: 1 = 32-count frame, 0 = 256-count frame |
| ctrl_div_sel | input | 2 | Prescaler select: divide by 16 << value |
| route_we | input | 1 | Write strobe for the routing bit |
| route_pwm | input | 1 | Routing bit: 1 = pin carries the waveform |
| port_val | input | 1 | General-purpose value driven on the pin when routing is off |
| pwm_wave | output | 1 | Registered PWM waveform |
| pin_out | output | 1 | Registered pin value after routing |

## Verification
The case that is hardest to reach is a duty write in the middle of a frame, because the frame boundary cannot be seen at the ports. The stimulus runs a short-mode frame at the largest duty, so the only rising edge of each frame marks its start. The duty is then rewritten a fixed number of clocks after that edge. The waveform is checked to stay high for the rest of that frame and to stay low through the next one. Steady-state behaviour is measured by counting high clocks over a window of exactly one frame, which gives the same result wherever the window starts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W   = 8;
  localparam int SHORT_W  = 5;
  localparam int SEL_W    = 2;
  localparam int DIV_LOG0 = 4;

  typedef struct packed {
    logic              short_mode;
    logic [SEL_W-1:0]  div_sel;
  } pwm_ctrl_t;

  function automatic logic [DATA_W-1:0] frame_last(input logic short_mode);
    return short_mode ? DATA_W'((1 << SHORT_W) - 1) : DATA_W'((1 << DATA_W) - 1);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W    = 2,
  parameter int DIV_LOG0 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 1 << SEL_W;
  localparam int CW   = DIV_LOG0 + NSEL - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term_tbl [NSEL];
  logic [CW-1:0] term;

  for (genvar i = 0; i < NSEL; i++) begin : g_term
    assign term_tbl[i] = CW'((1 << (DIV_LOG0 + i)) - 1);
  end

  assign term = term_tbl[sel];
  assign tick = (cnt_q >= term);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R4: the shortest divide is 16, so two ticks are never adjacent
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] duty_shadow,
  input  logic              short_shadow,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] act_duty
);
  localparam logic [DATA_W-1:0] SHORT_MASK = DATA_W'((1 << SHORT_W) - 1);

  logic [DATA_W-1:0] cnt_q, duty_q;
  logic              short_q;
  logic              wrap;

  assign wrap = tick && (cnt_q == frame_last(short_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      duty_q  <= '0;
      short_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      short_q <= short_shadow;
      duty_q  <= short_shadow ? (duty_shadow & SHORT_MASK) : duty_shadow;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt      = cnt_q;
  assign act_duty = duty_q;

  // R3: in short mode the counter never passes 31
  p_cnt_short_r3: assert property (@(posedge clk) disable iff (rst)
    short_q |-> (cnt_q <= SHORT_MASK));
  // R6: active settings change only at a frame wrap
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(duty_q) && $stable(short_q)));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] act_duty,
  input  logic              route_pwm,
  input  logic              port_val,
  output logic              wave,
  output logic              pin
);
  logic level;
  assign level = (cnt < act_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
      pin  <= 1'b0;
    end else begin
      wave <= level;
      pin  <= route_pwm ? level : port_val;
    end
  end

  // R5: zero duty gives a low waveform
  p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0) |=> !wave);
  // R7: routing off passes the port value with one clock of delay
  p_mux_port_r7: assert property (@(posedge clk) disable iff (rst)
    !route_pwm |=> (pin == $past(port_val)));
endmodule

// File: rtl/pwm_dualres.sv
module pwm_dualres
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              duty_we,
  input  logic [DATA_W-1:0] duty_wdata,
  input  logic              ctrl_we,
  input  logic              ctrl_short,
  input  logic [SEL_W-1:0]  ctrl_div_sel,
  input  logic              route_we,
  input  logic              route_pwm,
  input  logic              port_val,
  output logic              pwm_wave,
  output logic              pin_out
);
  logic [DATA_W-1:0] duty_q;
  pwm_ctrl_t         ctrl_q;
  logic              route_q;
  logic              tick;
  logic [DATA_W-1:0] cnt, act_duty;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q  <= '0;
      ctrl_q  <= '0;
      route_q <= 1'b0;
    end else begin
      if (duty_we)  duty_q  <= duty_wdata;
      if (ctrl_we)  ctrl_q  <= '{short_mode: ctrl_short, div_sel: ctrl_div_sel};
      if (route_we) route_q <= route_pwm;
    end
  end

  pwm_prescaler #(.SEL_W(SEL_W), .DIV_LOG0(DIV_LOG0)) u_pre (
    .clk(clk), .rst(rst), .sel(ctrl_q.div_sel), .tick(tick));

  pwm_frame_ctr u_frm (
    .clk(clk), .rst(rst), .tick(tick),
    .duty_shadow(duty_q), .short_shadow(ctrl_q.short_mode),
    .cnt(cnt), .act_duty(act_duty));

  pwm_out_stage u_out (
    .clk(clk), .rst(rst), .cnt(cnt), .act_duty(act_duty),
    .route_pwm(route_q), .port_val(port_val),
    .wave(pwm_wave), .pin(pin_out));

  // R1: the output is low on the first clock after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !pwm_wave);
endmodule

// File: tb/pwm_dualres_bench.sv
module pwm_dualres_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst = 1'b1;
  logic duty_we = 0, ctrl_we = 0, ctrl_short = 0, route_we = 0, route_pwm = 0, port_val = 0;
  logic [7:0] duty_wdata = '0;
  logic [1:0] ctrl_div_sel = '0;
  logic pwm_wave, pin_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dualres u_pwm_dualres (.*);

  typedef struct {
    int    window;
    int    exp_wave;
    int    exp_pin;
    string tag;
  } item_t;

  item_t sb_q[$];
  int n_run = 0, n_fail = 0, n_done = 0, n_push = 0;
  int old_period = 4096;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // monitor: count high clocks over one frame window
  initial begin
    forever begin
      item_t it;
      int hw, hp;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      hw = 0; hp = 0;
      for (int i = 0; i < it.window; i++) begin
        @(negedge clk);
        hw += int'(pwm_wave);
        hp += int'(pin_out);
      end
      chk({it.tag, " wave"}, hw, it.exp_wave);
      chk({it.tag, " pin"},  hp, it.exp_pin);
      n_done++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
        wrap_up();
      end
    end
  end

  task automatic write_cfg(input logic [7:0] d, input logic s, input logic [1:0] sel);
    @(negedge clk);
    duty_we = 1; duty_wdata = d; ctrl_we = 1; ctrl_short = s; ctrl_div_sel = sel;
    @(negedge clk);
    duty_we = 0; ctrl_we = 0;
  endtask

  task automatic set_route(input logic r);
    @(negedge clk);
    route_we = 1; route_pwm = r;
    @(negedge clk);
    route_we = 0;
  endtask

  // driver: configure, settle, push expectation, wait for monitor
  task automatic run_case(input logic [7:0] d, input logic s, input logic [1:0] sel,
                          input int m_eff, input logic routed, input string tag);
    int div, period, exp_w;
    div    = 16 << sel;
    period = div * (s ? 32 : 256);
    exp_w  = m_eff * div;
    write_cfg(d, s, sel);
    repeat (old_period + period + 4) @(negedge clk);
    sb_q.push_back('{period, exp_w, routed ? exp_w : (port_val ? period : 0), tag});
    n_push++;
    wait (n_done == n_push);
    old_period = period;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 wave low in reset", int'(pwm_wave), 0);
    rst = 0;
    repeat (100) @(negedge clk);
    chk("R1 wave low after reset", int'(pwm_wave), 0);
    port_val = 1; repeat (2) @(negedge clk);
    chk("R1 R7 pin follows port 1", int'(pin_out), 1);
    port_val = 0; repeat (2) @(negedge clk);
    chk("R7 pin follows port 0", int'(pin_out), 0);

    set_route(1);
    run_case(8'h80, 0, 2'd0, 128, 1, "R2 long M=128 div16");
    run_case(8'hFF, 0, 2'd0, 255, 1, "R5 long max");
    set_route(0);
    port_val = 1;
    run_case(8'h00, 0, 2'd0, 0, 0, "R5 R7 zero duty, port high");
    port_val = 0;
    set_route(1);
    run_case(8'hE5, 1, 2'd0, 5, 1, "R3 short masked 0xE5");
    run_case(8'h1F, 1, 2'd0, 31, 1, "R3 R5 short max");

    // R6: mid-frame duty rewrite keeps the current frame
    begin
      logic prev;
      prev = pwm_wave;
      forever begin
        @(negedge clk);
        if (!prev && pwm_wave) break;
        prev = pwm_wave;
      end
      repeat (100) @(negedge clk);
      duty_we = 1; duty_wdata = 8'h00;
      @(negedge clk);
      duty_we = 0;
      repeat (99) @(negedge clk);
      chk("R6 old duty holds mid-frame", int'(pwm_wave), 1);
      chk("R7 pin equals wave", int'(pin_out), int'(pwm_wave));
      repeat (400) @(negedge clk);
      chk("R6 new duty after wrap", int'(pwm_wave), 0);
      repeat (300) @(negedge clk);
      chk("R6 stays low in next frame", int'(pwm_wave), 0);
    end

    run_case(8'h10, 1, 2'd1, 16, 1, "R4 div32 short M=16");
    run_case(8'h03, 1, 2'd2, 3, 1, "R4 div64 short M=3");
    run_case(8'h01, 0, 2'd3, 1, 1, "R4 R2 div128 long M=1");
    wrap_up();
  end
endmodule